// File: doc/BRIEF.md
# Selectable-Width LSB-First Frame Check Generator

This block computes the check value that a packet framer appends after a frame payload. Before a frame, the host pulses `clear`, which presets the check register to all ones. The same pulse latches the width select, which picks the short 8-bit polynomial x^8+x^7+x^2+1 or the long 16-bit polynomial x^16+x^15+x^2+1. Payload bytes are then offered one at a time. Each accepted byte is folded into the register one bit per clock, least significant bit first, so the unit takes one byte every eight cycles.

When no byte is in progress, the bitwise inverse of the register is presented in parallel on `result`. The framer can also pull the check value out serially. Each `shift_en` cycle emits the inverse of the register's top bit on `serial_bit` and shifts a zero into the register. During shift-out the register is therefore a plain shift register with no feedback. A receiver can use the same unit by recomputing over the bytes it received and comparing the result with the check field it received.

Top module: `crc_dual_lsb`

## Requirements
- R1: After reset, `byte_ready` is 1, `result_valid` is 0, `serial_valid` is 0 and `result` is 0. The unit is in 8-bit mode.
- R2: A cycle with `clear` high has these effects from the next cycle on. The register is preset to all ones, so `result` reads 0. `result_valid` is 0 and `byte_ready` is 1. The mode is taken from `size_long`, where 0 selects 8 bits and 1 selects 16 bits.
- R3: In 8-bit mode the register advances by x^8+x^7+x^2+1 (tap mask 0x85), with byte bits taken bit 0 first. Each step XORs the input bit with register bit 7. The register shifts toward the MSB, and when that XOR is 1 the mask is applied. `result[7:0]` is the inverted register and `result[15:8]` is 0.
- R4: In 16-bit mode the register advances the same way using register bit 15 and the mask 0x8005 (x^16+x^15+x^2+1). `result` is the full 16-bit inverse.
- R5: A byte is taken on a cycle where `byte_valid` and `byte_ready` are high and `clear` is low. `byte_ready` then stays low for exactly 7 cycles. Any `byte_valid` during those cycles is ignored.
- R6: Successive bytes after a `clear` accumulate into one check value over the whole frame.
- R7: `result_valid` is 1 once at least one byte has been taken since `clear` and no byte is in progress. While no `clear`, `shift_en` or `byte_valid` occurs, `result` and `result_valid` hold their values.
- R8: A `shift_en` cycle counts when the unit is ready, no byte is taken in that cycle and `clear` is low. On the next cycle `serial_valid` is 1 and `serial_bit` is the inverse of the register's top bit (bit 7 or bit 15). The register then shifts toward the MSB with a 0 entering bit 0. The serial stream therefore gives `result` MSB first, and after a full width of shifts `result` reads all ones in the active width.
- R9: `shift_en` while a byte is in progress has no effect. `serial_valid` stays 0 and the final check value is unchanged.
- R10: `clear` takes priority over a simultaneous `byte_valid`, and that byte is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Preset the register and latch the width select |
| size_long | input | 1 | Width select sampled on clear: 0 = 8-bit, 1 = 16-bit |
| byte_valid | input | 1 | Payload byte offered |
| byte_in | input | 8 | Payload byte |
| byte_ready | output | 1 | Unit can take a byte this cycle |
| shift_en | input | 1 | Request one serial shift-out step |
| result | output | 16 | Inverted register, zero-extended in 8-bit mode |
| result_valid | output | 1 | Check value complete for the bytes taken so far |
| serial_bit | output | 1 | Serial check bit, MSB of result first |
| serial_valid | output | 1 | `serial_bit` holds a new bit |

## Verification
The bench builds the unit with its default parameters: an 8-bit byte and 8-bit and 16-bit polynomials. At these sizes every single-byte value can be swept in both modes, which covers every feedback pattern a lone byte can produce against the all-ones preset. Multi-byte frames, a complete serial drain past the register width, and the collisions of `clear`, `byte_valid` and `shift_en` with a byte in progress are also within reach.

// File: rtl/crc_dual_lsb_pkg.sv
package crc_dual_lsb_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned WIDE_W   = 16;
  localparam logic [WIDE_W-1:0] NARROW_TAPS = 16'h0085;
  localparam logic [WIDE_W-1:0] WIDE_TAPS   = 16'h8005;
endpackage

// File: rtl/crcu_bit_feeder.sv
module crcu_bit_feeder #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              bit_out,
  output logic              step,
  output logic              busy
);
  localparam int unsigned CW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] hold_q;
  logic [CW-1:0]     left_q;
  logic              busy_q;

  // first bit is consumed in the load cycle itself
  assign bit_out = load ? byte_in[0] : hold_q[0];
  assign step    = load | busy_q;
  assign busy    = busy_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hold_q <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      hold_q <= byte_in >> 1;
      left_q <= CW'(BYTE_W-1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      hold_q <= hold_q >> 1;
      left_q <= left_q - 1'b1;
      busy_q <= (left_q != CW'(1));
    end
  end

  assert_busy_after_load_R5: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> busy_q);
  assert_busy_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && left_q == CW'(1) && !clear) |=> !busy_q);
endmodule

// File: rtl/crcu_engine.sv
module crcu_engine #(
  parameter int unsigned WW = 16,
  parameter int unsigned NW = 8,
  parameter logic [WW-1:0] WTAPS = 16'h8005,
  parameter logic [WW-1:0] NTAPS = 16'h0085
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          preset,
  input  logic          step_en,
  input  logic          zero_fill,
  input  logic          din,
  input  logic          wide,
  output logic [WW-1:0] crc_q
);
  logic          top_bit;
  logic          fb;
  logic [WW-1:0] shifted;
  logic [WW-1:0] nxt;

  always_comb begin
    top_bit = wide ? crc_q[WW-1] : crc_q[NW-1];
    fb      = zero_fill ? 1'b0 : (top_bit ^ din);
    if (wide) shifted = {crc_q[WW-2:0], 1'b0};
    else      shifted = {crc_q[WW-1:NW], crc_q[NW-2:0], 1'b0};
    nxt = shifted ^ (fb ? (wide ? WTAPS : NTAPS) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || preset) crc_q <= '1;
    else if (step_en)  crc_q <= nxt;
  end

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !preset) |=> $stable(crc_q));
endmodule

// File: rtl/crc_dual_lsb.sv
module crc_dual_lsb
  import crc_dual_lsb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                size_long,
  input  logic                byte_valid,
  input  logic [BYTE_W-1:0]   byte_in,
  output logic                byte_ready,
  input  logic                shift_en,
  output logic [WIDE_W-1:0]   result,
  output logic                result_valid,
  output logic                serial_bit,
  output logic                serial_valid
);
  logic              wide_q, have_q, busy, feed_bit, feed_step;
  logic              accept, shift_go, ser_bit_q, ser_vld_q;
  logic [WIDE_W-1:0] crc_q;

  assign accept   = byte_valid & ~busy & ~clear;
  assign shift_go = shift_en & ~busy & ~byte_valid & ~clear;

  crcu_bit_feeder #(.BYTE_W(BYTE_W)) u_feed (
    .clk(clk), .rst(rst), .clear(clear), .load(accept), .byte_in(byte_in),
    .bit_out(feed_bit), .step(feed_step), .busy(busy));

  crcu_engine #(.WW(WIDE_W), .NW(NARROW_W), .WTAPS(WIDE_TAPS), .NTAPS(NARROW_TAPS)) u_eng (
    .clk(clk), .rst(rst), .preset(clear), .step_en(feed_step | shift_go),
    .zero_fill(shift_go), .din(feed_bit), .wide(wide_q), .crc_q(crc_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q    <= 1'b0;
      have_q    <= 1'b0;
      ser_bit_q <= 1'b0;
      ser_vld_q <= 1'b0;
    end else begin
      if (clear)       wide_q <= size_long;
      if (clear)       have_q <= 1'b0;
      else if (accept) have_q <= 1'b1;
      ser_vld_q <= shift_go;
      if (shift_go)
        ser_bit_q <= ~(wide_q ? crc_q[WIDE_W-1] : crc_q[NARROW_W-1]);
    end
  end

  assign result       = wide_q ? ~crc_q : {{(WIDE_W-NARROW_W){1'b0}}, ~crc_q[NARROW_W-1:0]};
  assign result_valid = have_q & ~busy;
  assign byte_ready   = ~busy;
  assign serial_bit   = ser_bit_q;
  assign serial_valid = ser_vld_q;

  assert_clear_presets_R2: assert property (@(posedge clk) disable iff (rst)
    clear |=> (result == '0 && !result_valid && byte_ready));
  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (clear && byte_valid) |=> byte_ready);
  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_ready && !clear) |=> !byte_ready);
  assert_result_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (result_valid && !clear && !shift_en && !byte_valid) |=> ($stable(result) && result_valid));
  assert_no_shift_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (!byte_ready && !clear) |=> !serial_valid);
  assert_serial_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
    serial_valid |-> $past(shift_en));
endmodule

// File: tb/tb_crc_dual_lsb.sv
module tb_crc_dual_lsb;
  logic clk = 1'b0, rst = 1'b1, clear = 1'b0, size_long = 1'b0;
  logic byte_valid = 1'b0, shift_en = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        byte_ready, result_valid, serial_bit, serial_valid;
  logic [15:0] result;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] frame [16];

  always #5 clk = ~clk;

  crc_dual_lsb dut (.clk(clk), .rst(rst), .clear(clear), .size_long(size_long),
    .byte_valid(byte_valid), .byte_in(byte_in), .byte_ready(byte_ready),
    .shift_en(shift_en), .result(result), .result_valid(result_valid),
    .serial_bit(serial_bit), .serial_valid(serial_valid));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n, input logic wide);
    logic [15:0] c = 16'hFFFF;
    logic fb;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        if (wide) begin
          fb = c[15] ^ frame[i][b];
          c  = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
        end else begin
          fb = c[7] ^ frame[i][b];
          c[7:0] = {c[6:0], 1'b0} ^ (fb ? 8'h85 : 8'h00);
        end
      end
    return wide ? ~c : {8'h00, ~c[7:0]};
  endfunction

  task automatic do_clear(input logic w);
    size_long = w; clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    while (!byte_ready) @(negedge clk);
    byte_valid = 1'b1; byte_in = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!byte_ready) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input logic w, input string tag);
    do_clear(w);
    for (int i = 0; i < n; i++) send_byte(frame[i]);
    wait_idle();
    chk(tag, result, ref_crc(n, w));
    chk({tag, " valid"}, {15'd0, result_valid}, 16'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {15'd0, byte_ready}, 16'd1);
    chk("R1 valid", {15'd0, result_valid}, 16'd0);
    chk("R1 serial_valid", {15'd0, serial_valid}, 16'd0);
    chk("R1 result", result, 16'h0000);

    // R2 clear preset
    do_clear(1'b1);
    chk("R2 result after clear", result, 16'h0000);
    chk("R2 valid after clear", {15'd0, result_valid}, 16'd0);

    // R3 sweep every byte, 8-bit mode
    for (int v = 0; v < 256; v++) begin
      frame[0] = 8'(v);
      run_frame(1, 1'b0, "R3 narrow byte");
    end
    // R4 sweep every byte, 16-bit mode
    for (int v = 0; v < 256; v++) begin
      frame[0] = 8'(v);
      run_frame(1, 1'b1, "R4 wide byte");
    end

    // R6 multi-byte frames
    frame[0] = 8'h1B; frame[1] = 8'h0B; frame[2] = 8'hF5;
    run_frame(3, 1'b0, "R6 narrow 3B");
    run_frame(3, 1'b1, "R6 wide 3B");
    for (int i = 0; i < 16; i++) frame[i] = 8'((i * 37 + 11) ^ (i << 4));
    run_frame(16, 1'b0, "R6 narrow 16B");
    run_frame(16, 1'b1, "R6 wide 16B");

    // R7 hold after last byte
    e = result;
    repeat (20) @(negedge clk);
    chk("R7 stable result", result, e);
    chk("R7 stable valid", {15'd0, result_valid}, 16'd1);

    // R8 serial drain, 16-bit
    for (int k = 0; k < 16; k++) begin
      shift_en = 1'b1;
      @(negedge clk);
      chk("R8 wide serial_valid", {15'd0, serial_valid}, 16'd1);
      chk("R8 wide serial_bit", {15'd0, serial_bit}, {15'd0, e[15-k]});
    end
    @(negedge clk);
    chk("R8 wide extra zero-fill bit", {15'd0, serial_bit}, 16'd1);
    shift_en = 1'b0;
    chk("R8 wide result after drain", result, 16'hFFFF);
    @(negedge clk);
    chk("R8 serial_valid drops", {15'd0, serial_valid}, 16'd0);

    // R8 serial drain, 8-bit
    frame[0] = 8'hF5; frame[1] = 8'h3C;
    run_frame(2, 1'b0, "R8 narrow frame");
    e = result;
    for (int k = 0; k < 8; k++) begin
      shift_en = 1'b1;
      @(negedge clk);
      chk("R8 narrow serial_bit", {15'd0, serial_bit}, {15'd0, e[7-k]});
    end
    shift_en = 1'b0;
    chk("R8 narrow result after drain", result, 16'h00FF);

    // R5 + R9: ready timing, junk byte_valid and shift_en while busy
    frame[0] = 8'hA7;
    do_clear(1'b1);
    byte_valid = 1'b1; byte_in = 8'hA7;
    @(negedge clk);
    byte_in = 8'h5E; shift_en = 1'b1;
    begin
      int low = 0;
      for (int c = 0; c < 6; c++) begin
        if (!byte_ready) low++;
        chk("R9 no serial while busy", {15'd0, serial_valid}, 16'd0);
        @(negedge clk);
      end
      byte_valid = 1'b0; shift_en = 1'b0;
      if (!byte_ready) low++;
      @(negedge clk);
      chk("R5 ready low cycles", 16'(low), 16'd7);
      chk("R5 ready back", {15'd0, byte_ready}, 16'd1);
    end
    chk("R5 R9 result ignores busy inputs", result, ref_crc(1, 1'b1));

    // R10 clear beats byte_valid
    size_long = 1'b0; clear = 1'b1; byte_valid = 1'b1; byte_in = 8'h77;
    @(negedge clk);
    clear = 1'b0; byte_valid = 1'b0;
    chk("R10 ready", {15'd0, byte_ready}, 16'd1);
    chk("R10 valid", {15'd0, result_valid}, 16'd0);
    chk("R10 result", result, 16'h0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule